// File: doc/BRIEF.md
# Interrupt Router Register Window

This block is the bus slave of an interrupt router. It exposes the router's registers through two locations: an index register and a 32-bit data window. Software first writes a register number into the index register, then reads or writes that register through the window. The block decodes only the low byte of the bus address, so the same two locations repeat across the whole address range.

The index can select an identification register, a read-only version register, an arbitration register that always reads zero, or one half of a 64-bit redirection entry. Entries sit at even/odd index pairs above a table base. Even indices select the lower half and odd indices the upper half. The entry contents live in the router. The block drives an entry select and reads the entry back from the router. On an entry write it sends a half-word update strobe and then pulses a re-evaluation request. Window accesses are honoured only when the size qualifier says four bytes.

Each bus request is handled by a four-state machine. `ST_IDLE` is ready and takes a request (transition *accept*, to `ST_DECODE`). `ST_DECODE` resolves the target, captures read data and performs the write. It leaves by *entry-write* to `ST_KICK` or by *finish* to `ST_DONE`. `ST_KICK` raises the re-evaluation pulse and goes to `ST_DONE` by *kicked*. `ST_DONE` presents the response for one cycle and returns to `ST_IDLE` by *release*.

Top module: `irq_route_regwin`

## Requirements
- R1: Only address bits 7:0 are decoded. Offset 0x00 is the index register and offset 0x10 is the data window. Higher address bits are ignored. Any other offset reads 0, and a write to it changes nothing.
- R2: The 8-bit index register can be written and read back at offset 0x00 with any size code. A read returns it zero-extended.
- R3: Size code 2 (four bytes) is the only window size that takes effect. Codes 0 (one byte), 1 (two bytes) and 3 (eight bytes) read 0 through the window, and a write with them updates nothing and raises no strobe.
- R4: Index 0 is the identification register. A write stores write-data bits 27:24. A read returns the stored 4-bit value in bits 27:24 and zeros elsewhere. Reset value 0.
- R5: Index 1 is the version register. It reads version code 0x11 ORed with (pin count − 1) in bits 23:16, which is 0x00170011 for 24 pins. Writes are ignored.
- R6: Index 2 is the arbitration register. It always reads 0 and ignores writes.
- R7: An index at or above the table base 0x10 selects entry (index − 0x10) >> 1. An odd index reaches entry bits 63:32 and an even index reaches bits 31:0.
- R8: Indices 3 to 0x0F, and indices at or above 0x10 + 2 × pin count, read 0 and raise no update strobe when written.
- R9: A valid 4-byte entry write raises `ent_wr` for one cycle. It carries the entry number on `ent_sel`, the half on `ent_wr_hi` (1 means upper) and the data on `ent_wdata`, so only that half is replaced. `ent_reeval` pulses in the cycle right after.
- R10: `req_ready` is high only in `ST_IDLE`. `rsp_valid` is a one-cycle pulse two cycles after acceptance, or three cycles after acceptance for an entry write. `rsp_rdata` carries the read value and is 0 for writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request present |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address; bits 7:0 decoded |
| req_size | input | 2 | Access size: 0=1B, 1=2B, 2=4B, 3=8B |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response pulse |
| rsp_rdata | output | 32 | Read data |
| ent_sel | output | ENT_W | Entry number addressed by the index |
| ent_rdata | input | 64 | Contents of the selected entry from the router |
| ent_wr | output | 1 | Entry half update strobe |
| ent_wr_hi | output | 1 | Half being updated: 1 upper, 0 lower |
| ent_wdata | output | 32 | Data for the updated half |
| ent_reeval | output | 1 | Re-evaluation request after an entry update |

## Verification
Assertions check on every cycle the sequencing rules. An update strobe is always followed by exactly one re-evaluation pulse, which only ever comes from a strobe. No strobe comes from an access that is not four bytes wide. Narrow window reads return zero, the response lasts a single cycle, and the version value is fixed. Some behaviour can only be shown by the directed scenarios. These are the decoding of every index class, the placement of the identification field, half selection and half preservation in the router's copy, aliasing of high address bits, and exact response latencies.

// File: rtl/irw_pkg.sv
package irw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DECODE,
        ST_KICK,
        ST_DONE
    } irw_state_e;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_INDEX,
        TGT_ID,
        TGT_VER,
        TGT_ARB,
        TGT_ENTRY
    } irw_tgt_e;

    localparam logic [1:0] SZ_WORD = 2'd2;

    localparam int IDX_ID  = 0;
    localparam int IDX_VER = 1;
    localparam int IDX_ARB = 2;

endpackage

// File: rtl/irw_decode.sv
module irw_decode
    import irw_pkg::*;
#(
    parameter int          NUM_PINS   = 24,
    parameter int          IDX_W      = 8,
    parameter int          ENT_W      = 5,
    parameter int          TBL_BASE   = 16,
    parameter logic [7:0]  OFS_INDEX  = 8'h00,
    parameter logic [7:0]  OFS_WINDOW = 8'h10
) (
    input  logic [7:0]       ofs,
    input  logic [IDX_W-1:0] idx,
    input  logic [1:0]       size,
    output irw_tgt_e         tgt,
    output logic [ENT_W-1:0] ent,
    output logic             hi
);

    localparam int LAST_IDX = TBL_BASE + 2 * NUM_PINS - 1;

    logic [IDX_W-1:0] rel;
    logic             in_tbl;
    logic             unused_rel;

    assign rel        = idx - IDX_W'(TBL_BASE);
    assign in_tbl     = (int'(idx) >= TBL_BASE) && (int'(idx) <= LAST_IDX);
    assign unused_rel = ^{rel[IDX_W-1:ENT_W+1], rel[0]};
    assign ent        = in_tbl ? rel[ENT_W:1] : '0;
    assign hi         = idx[0];

    always_comb begin
        tgt = TGT_NONE;
        if (ofs == OFS_INDEX) begin
            tgt = TGT_INDEX;
        end else if (ofs == OFS_WINDOW && size == SZ_WORD) begin
            if (int'(idx) == IDX_ID) begin
                tgt = TGT_ID;
            end else if (int'(idx) == IDX_VER) begin
                tgt = TGT_VER;
            end else if (int'(idx) == IDX_ARB) begin
                tgt = TGT_ARB;
            end else if (in_tbl) begin
                tgt = TGT_ENTRY;
            end
        end
    end

endmodule

// File: rtl/irw_regs.sv
module irw_regs #(
    parameter int IDX_W = 8,
    parameter int ID_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idx_we,
    input  logic [IDX_W-1:0] idx_wdata,
    input  logic             id_we,
    input  logic [ID_W-1:0]  id_wdata,
    output logic [IDX_W-1:0] index_q,
    output logic [ID_W-1:0]  id_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            index_q <= '0;
            id_q    <= '0;
        end else begin
            if (idx_we) begin
                index_q <= idx_wdata;
            end
            if (id_we) begin
                id_q <= id_wdata;
            end
        end
    end

endmodule

// File: rtl/irw_fsm.sv
module irw_fsm
    import irw_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     req_valid,
    input  logic     lat_write,
    input  irw_tgt_e tgt,
    output logic     req_ready,
    output logic     accept,
    output logic     exec,
    output logic     ent_wr,
    output logic     ent_reeval,
    output logic     rsp_valid
);

    irw_state_e state_q;
    irw_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_DECODE;
            ST_DECODE: state_d = (lat_write && tgt == TGT_ENTRY) ? ST_KICK : ST_DONE;
            ST_KICK:   state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready  = 1'b0;
        accept     = 1'b0;
        exec       = 1'b0;
        ent_wr     = 1'b0;
        ent_reeval = 1'b0;
        rsp_valid  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                accept    = req_valid;
            end
            ST_DECODE: begin
                exec   = 1'b1;
                ent_wr = lat_write && (tgt == TGT_ENTRY);
            end
            ST_KICK:  ent_reeval = 1'b1;
            ST_DONE:  rsp_valid  = 1'b1;
            default: ;
        endcase
    end

    // R9: every update strobe is followed by a re-evaluation pulse
    p_kick_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ent_wr |=> ent_reeval);

    // R9: a re-evaluation pulse only comes from an update strobe
    p_kick_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ent_reeval |-> $past(ent_wr));

    // R10: response lasts one cycle and the block is ready afterwards
    p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));

endmodule

// File: rtl/irq_route_regwin.sv
module irq_route_regwin
    import irw_pkg::*;
#(
    parameter int          NUM_PINS     = 24,
    parameter int          ADDR_W       = 12,
    parameter int          IDX_W        = 8,
    parameter int          ID_W         = 4,
    parameter int          ID_SHIFT     = 24,
    parameter int          MAXENT_SHIFT = 16,
    parameter logic [7:0]  VERSION      = 8'h11,
    parameter int          TBL_BASE     = 16,
    parameter logic [7:0]  OFS_INDEX    = 8'h00,
    parameter logic [7:0]  OFS_WINDOW   = 8'h10,
    localparam int         ENT_W        = $clog2(NUM_PINS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic [ENT_W-1:0]  ent_sel,
    input  logic [63:0]       ent_rdata,
    output logic              ent_wr,
    output logic              ent_wr_hi,
    output logic [31:0]       ent_wdata,
    output logic              ent_reeval
);

    localparam logic [31:0] VER_VALUE =
        32'(VERSION) | (32'(NUM_PINS - 1) << MAXENT_SHIFT);

    logic [7:0]       lat_ofs;
    logic             lat_write;
    logic [1:0]       lat_size;
    logic [31:0]      lat_wdata;
    logic [31:0]      rdata_q;
    logic [31:0]      rd_mux;
    logic [IDX_W-1:0] index_q;
    logic [ID_W-1:0]  id_q;
    irw_tgt_e         tgt;
    logic [ENT_W-1:0] ent;
    logic             hi;
    logic             accept;
    logic             exec;
    logic             unused_addr_hi;

    assign unused_addr_hi = ^req_addr[ADDR_W-1:8];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_ofs   <= '0;
            lat_write <= 1'b0;
            lat_size  <= '0;
            lat_wdata <= '0;
            rdata_q   <= '0;
        end else begin
            if (accept) begin
                lat_ofs   <= req_addr[7:0];
                lat_write <= req_write;
                lat_size  <= req_size;
                lat_wdata <= req_wdata;
            end
            if (exec) begin
                rdata_q <= lat_write ? 32'd0 : rd_mux;
            end
        end
    end

    irw_decode #(
        .NUM_PINS   (NUM_PINS),
        .IDX_W      (IDX_W),
        .ENT_W      (ENT_W),
        .TBL_BASE   (TBL_BASE),
        .OFS_INDEX  (OFS_INDEX),
        .OFS_WINDOW (OFS_WINDOW)
    ) u_decode (
        .ofs  (lat_ofs),
        .idx  (index_q),
        .size (lat_size),
        .tgt  (tgt),
        .ent  (ent),
        .hi   (hi)
    );

    irw_regs #(
        .IDX_W (IDX_W),
        .ID_W  (ID_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx_we    (exec && lat_write && tgt == TGT_INDEX),
        .idx_wdata (lat_wdata[IDX_W-1:0]),
        .id_we     (exec && lat_write && tgt == TGT_ID),
        .id_wdata  (lat_wdata[ID_SHIFT +: ID_W]),
        .index_q   (index_q),
        .id_q      (id_q)
    );

    irw_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .lat_write  (lat_write),
        .tgt        (tgt),
        .req_ready  (req_ready),
        .accept     (accept),
        .exec       (exec),
        .ent_wr     (ent_wr),
        .ent_reeval (ent_reeval),
        .rsp_valid  (rsp_valid)
    );

    always_comb begin
        case (tgt)
            TGT_INDEX: rd_mux = 32'(index_q);
            TGT_ID:    rd_mux = 32'(id_q) << ID_SHIFT;
            TGT_VER:   rd_mux = VER_VALUE;
            TGT_ENTRY: rd_mux = hi ? ent_rdata[63:32] : ent_rdata[31:0];
            default:   rd_mux = 32'd0;
        endcase
    end

    assign rsp_rdata = rdata_q;
    assign ent_sel   = ent;
    assign ent_wr_hi = hi;
    assign ent_wdata = lat_wdata;

    // R3: an update strobe only comes from a four-byte access
    p_wr_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ent_wr |-> (lat_size == SZ_WORD));

    // R3: a narrow window read returns zero
    p_narrow_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !lat_write && lat_ofs == OFS_WINDOW && lat_size != SZ_WORD)
        |-> (rsp_rdata == 32'd0));

    // R5: the version register always returns its fixed value
    p_ver_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !lat_write && lat_ofs == OFS_WINDOW && lat_size == SZ_WORD
         && int'(index_q) == IDX_VER) |-> (rsp_rdata == VER_VALUE));

    // R8: an entry target always names an existing entry
    p_ent_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt == TGT_ENTRY) |-> (int'(ent_sel) < NUM_PINS));

endmodule

// File: tb/irq_route_regwin_tb.sv
`timescale 1ns/1ps
module irq_route_regwin_tb;

    localparam int NUM_PINS = 24;
    localparam int ADDR_W   = 12;
    localparam int ENT_W    = $clog2(NUM_PINS);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [1:0]        req_size = 2'd2;
    logic [31:0]       req_wdata = '0;
    logic              rsp_valid;
    logic [31:0]       rsp_rdata;
    logic [ENT_W-1:0]  ent_sel;
    logic [63:0]       ent_rdata;
    logic              ent_wr;
    logic              ent_wr_hi;
    logic [31:0]       ent_wdata;
    logic              ent_reeval;

    int n_checks = 0;
    int n_fail   = 0;
    int wr_cnt   = 0;
    int kick_cnt = 0;
    bit finished = 1'b0;

    logic [63:0] tbl [NUM_PINS];

    always #2.5 clk = ~clk;

    irq_route_regwin u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_size   (req_size),
        .req_wdata  (req_wdata),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata),
        .ent_sel    (ent_sel),
        .ent_rdata  (ent_rdata),
        .ent_wr     (ent_wr),
        .ent_wr_hi  (ent_wr_hi),
        .ent_wdata  (ent_wdata),
        .ent_reeval (ent_reeval)
    );

    function automatic logic [63:0] init_val(int i);
        return {32'hA000_0000 + 32'(i), 32'h0001_0000 | 32'(i)};
    endfunction

    // router model: holds the entries, merges half updates, counts strobes
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_PINS; i++) tbl[i] <= init_val(i);
        end else begin
            if (ent_wr) begin
                wr_cnt <= wr_cnt + 1;
                if (ent_wr_hi) tbl[ent_sel][63:32] <= ent_wdata;
                else           tbl[ent_sel][31:0]  <= ent_wdata;
            end
            if (ent_reeval) kick_cnt <= kick_cnt + 1;
        end
    end

    assign ent_rdata = (int'(ent_sel) < NUM_PINS) ? tbl[ent_sel] : 64'd0;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [ADDR_W-1:0] addr,
                          input logic [1:0] size, input logic [31:0] wdata,
                          output logic [31:0] rdata, output int lat);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = addr;
        req_size  = size;
        req_wdata = wdata;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_valid && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        rdata = rsp_rdata;
    endtask

    task automatic wr_reg(input logic [ADDR_W-1:0] addr, input logic [1:0] size,
                          input logic [31:0] d);
        logic [31:0] r;
        int l;
        access(1'b1, addr, size, d, r, l);
    endtask

    task automatic rd_reg(input logic [ADDR_W-1:0] addr, input logic [1:0] size,
                          output logic [31:0] r);
        int l;
        access(1'b0, addr, size, 32'd0, r, l);
    endtask

    task automatic t_reset();
        logic [31:0] r;
        @(negedge clk);
        check("R10 reset ready", 32'(req_ready), 32'd1);
        check("R10 reset rsp_valid", 32'(rsp_valid), 32'd0);
        check("R9 reset strobes", 32'({ent_wr, ent_reeval}), 32'd0);
        rd_reg(12'h000, 2'd2, r);
        check("R2 reset index", r, 32'd0);
        rd_reg(12'h010, 2'd2, r);
        check("R4 reset id", r, 32'd0);
    endtask

    task automatic t_index();
        logic [31:0] r;
        wr_reg(12'h000, 2'd0, 32'hFFFF_FFA5);
        rd_reg(12'h000, 2'd1, r);
        check("R2 index readback", r, 32'h0000_00A5);
    endtask

    task automatic t_offsets();
        logic [31:0] r;
        int w0;
        wr_reg(12'h000, 2'd2, 32'd1);
        rd_reg(12'h310, 2'd2, r);
        check("R1 high address bits ignored", r, 32'h0017_0011);
        rd_reg(12'h004, 2'd2, r);
        check("R1 unused offset reads zero", r, 32'd0);
        wr_reg(12'h000, 2'd2, 32'h1A);
        w0 = wr_cnt;
        wr_reg(12'h020, 2'd2, 32'h5555_5555);
        rd_reg(12'h000, 2'd2, r);
        check("R1 unused offset write keeps index", r, 32'h1A);
        check("R1 unused offset write no strobe", 32'(wr_cnt - w0), 32'd0);
    endtask

    task automatic t_id();
        logic [31:0] r;
        wr_reg(12'h000, 2'd2, 32'd0);
        wr_reg(12'h010, 2'd2, 32'hFAFF_FFFF);
        rd_reg(12'h010, 2'd2, r);
        check("R4 id field", r, 32'h0A00_0000);
    endtask

    task automatic t_version();
        logic [31:0] r;
        wr_reg(12'h000, 2'd2, 32'd1);
        wr_reg(12'h010, 2'd2, 32'hFFFF_FFFF);
        rd_reg(12'h010, 2'd2, r);
        check("R5 version after write", r, 32'h0017_0011);
    endtask

    task automatic t_arb();
        logic [31:0] r;
        int w0;
        wr_reg(12'h000, 2'd2, 32'd2);
        w0 = wr_cnt;
        wr_reg(12'h010, 2'd2, 32'hFFFF_FFFF);
        rd_reg(12'h010, 2'd2, r);
        check("R6 arbitration reads zero", r, 32'd0);
        check("R6 arbitration write no strobe", 32'(wr_cnt - w0), 32'd0);
    endtask

    task automatic t_entry_read();
        logic [31:0] r;
        int l;
        wr_reg(12'h000, 2'd2, 32'h1A);
        access(1'b0, 12'h010, 2'd2, 32'd0, r, l);
        check("R7 entry 5 low half", r, init_val(5)[31:0]);
        check("R10 read latency", 32'(l), 32'd2);
        wr_reg(12'h000, 2'd2, 32'h1B);
        rd_reg(12'h010, 2'd2, r);
        check("R7 entry 5 high half", r, init_val(5)[63:32]);
        wr_reg(12'h000, 2'd2, 32'h3F);
        rd_reg(12'h010, 2'd2, r);
        check("R7 last entry high half", r, init_val(23)[63:32]);
        wr_reg(12'h000, 2'd2, 32'h10);
        rd_reg(12'h010, 2'd2, r);
        check("R7 first entry low half", r, init_val(0)[31:0]);
    endtask

    task automatic t_entry_write();
        logic [31:0] r;
        int l, w0, k0;
        wr_reg(12'h000, 2'd2, 32'h1A);
        w0 = wr_cnt;
        k0 = kick_cnt;
        access(1'b1, 12'h010, 2'd2, 32'h1234_5678, r, l);
        check("R10 entry write latency", 32'(l), 32'd3);
        check("R10 write response data", r, 32'd0);
        check("R9 one strobe", 32'(wr_cnt - w0), 32'd1);
        check("R9 one reeval", 32'(kick_cnt - k0), 32'd1);
        rd_reg(12'h010, 2'd2, r);
        check("R9 low half written", r, 32'h1234_5678);
        wr_reg(12'h000, 2'd2, 32'h1B);
        rd_reg(12'h010, 2'd2, r);
        check("R9 high half kept", r, init_val(5)[63:32]);
        wr_reg(12'h010, 2'd2, 32'hCAFE_0001);
        rd_reg(12'h010, 2'd2, r);
        check("R9 high half written", r, 32'hCAFE_0001);
        wr_reg(12'h000, 2'd2, 32'h1A);
        rd_reg(12'h010, 2'd2, r);
        check("R9 low half kept", r, 32'h1234_5678);
    endtask

    task automatic t_narrow();
        logic [31:0] r;
        int w0;
        wr_reg(12'h000, 2'd2, 32'h1A);
        for (int s = 0; s < 4; s++) begin
            if (s != 2) begin
                rd_reg(12'h010, 2'(s), r);
                check("R3 narrow window read", r, 32'd0);
            end
        end
        w0 = wr_cnt;
        wr_reg(12'h010, 2'd1, 32'h0000_DEAD);
        wr_reg(12'h010, 2'd3, 32'hBEEF_0000);
        check("R3 narrow write no strobe", 32'(wr_cnt - w0), 32'd0);
        rd_reg(12'h010, 2'd2, r);
        check("R3 entry unchanged", r, 32'h1234_5678);
        wr_reg(12'h000, 2'd2, 32'd0);
        wr_reg(12'h010, 2'd0, 32'h0F00_0000);
        rd_reg(12'h010, 2'd2, r);
        check("R3 id unchanged by byte write", r, 32'h0A00_0000);
    endtask

    task automatic t_out_of_range();
        logic [31:0] r;
        int w0, k0;
        logic [7:0] idxs [3] = '{8'h03, 8'h0F, 8'h40};
        for (int i = 0; i < 3; i++) begin
            wr_reg(12'h000, 2'd2, 32'(idxs[i]));
            w0 = wr_cnt;
            k0 = kick_cnt;
            wr_reg(12'h010, 2'd2, 32'h7777_7777);
            rd_reg(12'h010, 2'd2, r);
            check("R8 out of range reads zero", r, 32'd0);
            check("R8 out of range no strobe", 32'(wr_cnt - w0 + kick_cnt - k0), 32'd0);
        end
    endtask

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_index();
        t_offsets();
        t_id();
        t_version();
        t_arb();
        t_entry_read();
        t_entry_write();
        t_narrow();
        t_out_of_range();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule